// File: doc/BRIEF.md
# Memory-Side Coherence State Tracker

This block is the memory controller's record of where each cache line lives on a snooping bus that keeps lines in modified, shared or invalid form, and whose responses arrive some cycles after a request. It keeps one entry per line in a small, directly indexed table. Each entry holds a state and a data word. There are three states: *clean*, where no cache owns the line and memory holds valid data; *owned*, where exactly one cache holds the line modified; and *waiting*, where memory is waiting for the former owner to hand back its copy.

The bus presents one request per cycle at most: a shared read, an exclusive read, or a release (the owner giving up a modified line). Requests are already serialised and carry the requestor's ID. When memory is the one that must answer, it returns the line's data tagged with that ID after a fixed, configurable latency. A separate input carries data coming back from an owner. That data is stored and the line becomes clean again. A request that reaches a waiting line breaks the rule that transactions on one line are atomic. Data from an owner that arrives for a line that is not waiting also breaks the protocol. Both are reported on an error output and otherwise ignored.

Top module: `memside_coh_tracker`

## Requirements
- R1: After reset, or after a reset in the middle of a run, every line is clean with data zero, and `rsp_valid` and `proto_err` are low.
- R2: A shared read (`req_op` = 2'b01) to a clean line produces one response carrying the line's data, the request's `req_src` and `req_addr`. The line stays clean.
- R3: An exclusive read (`req_op` = 2'b10) to a clean line produces one response with the line's data and makes the line owned.
- R4: A shared read, or a release (`req_op` = 2'b11), to an owned line produces no response and no error, and the line becomes waiting.
- R5: An exclusive read to an owned line produces no response and no error, and the line stays owned.
- R6: Owner data (`wb_valid`) for a waiting line is stored and makes the line clean without raising an error.
- R7: A request of any kind to a waiting line raises `proto_err` for exactly one cycle, on the cycle after it is presented. It produces no response and leaves the line's state and data unchanged.
- R8: Owner data for a line that is not waiting raises `proto_err` one cycle later and is discarded.
- R9: A response is valid for exactly one cycle. The request is sampled on an edge, and the response appears after the clock edge RSP_LAT−1 cycles later. Requests on consecutive cycles give responses on consecutive cycles.
- R10: If owner data for a waiting line and a request for the same line arrive in the same cycle, the data is stored first. The request then acts on a clean line, and any response carries the new data.
- R11: A release to a clean line is ignored: no response, no error, and the line stays clean.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A bus request is present this cycle |
| req_op | input | 2 | 01 shared read, 10 exclusive read, 11 release, 00 none |
| req_addr | input | IDX_W | Line index of the request |
| req_src | input | ID_W | Requestor ID |
| wb_valid | input | 1 | Owner data is present this cycle |
| wb_addr | input | IDX_W | Line index of the owner data |
| wb_data | input | DATA_W | Owner data word |
| rsp_valid | output | 1 | Data response valid |
| rsp_dst | output | ID_W | Requestor ID the response is for |
| rsp_addr | output | IDX_W | Line index of the response |
| rsp_data | output | DATA_W | Line data being returned |
| proto_err | output | 1 | One-cycle pulse on a protocol violation |

## Verification
Two functions can act on the same line in one cycle: storing an owner's returned data, and serving a new request. The bench first puts a line into the waiting state. It then presents a shared read and the owner's data for that line together, in one cycle. The result counts as correct if no error is raised and the response carries the freshly returned word. A following exclusive read must then also be served with that word, which shows the line really ended up clean.

// File: rtl/coh_mem_pkg.sv
package coh_mem_pkg;

    typedef enum logic [1:0] {
        LN_CLEAN  = 2'b00,
        LN_WAITWB = 2'b01,
        LN_OWNED  = 2'b10
    } line_st_e;

    typedef enum logic [1:0] {
        BUS_IDLE      = 2'b00,
        BUS_RD_SHARED = 2'b01,
        BUS_RD_EXCL   = 2'b10,
        BUS_RELEASE   = 2'b11
    } bus_op_e;

    typedef struct packed {
        line_st_e nxt;
        logic     wr;
        logic     send;
        logic     err;
    } req_act_t;

    function automatic req_act_t req_decide(input line_st_e cur, input bus_op_e op);
        req_act_t a;
        a.nxt  = cur;
        a.wr   = 1'b0;
        a.send = 1'b0;
        a.err  = 1'b0;
        if (op != BUS_IDLE) begin
            unique case (cur)
                LN_CLEAN: begin
                    if (op == BUS_RD_SHARED) begin
                        a.send = 1'b1;
                    end else if (op == BUS_RD_EXCL) begin
                        a.send = 1'b1;
                        a.wr   = 1'b1;
                        a.nxt  = LN_OWNED;
                    end
                end
                LN_OWNED: begin
                    if (op != BUS_RD_EXCL) begin
                        a.wr  = 1'b1;
                        a.nxt = LN_WAITWB;
                    end
                end
                default: a.err = 1'b1;
            endcase
        end
        return a;
    endfunction

endpackage

// File: rtl/coh_line_array.sv
module coh_line_array
    import coh_mem_pkg::*;
#(
    parameter int NUM_LINES = 16,
    parameter int DATA_W    = 32,
    localparam int IDX_W    = $clog2(NUM_LINES)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [IDX_W-1:0]           rd_a_idx,
    output line_st_e                   rd_a_st,
    output logic [DATA_W-1:0]          rd_a_dat,
    input  logic [IDX_W-1:0]           rd_b_idx,
    output line_st_e                   rd_b_st,
    input  logic                       own_we,
    input  logic [IDX_W-1:0]           own_idx,
    input  logic [DATA_W-1:0]          own_dat,
    input  logic                       req_we,
    input  logic [IDX_W-1:0]           req_idx,
    input  line_st_e                   req_nxt,
    output logic [NUM_LINES-1:0][1:0]  st_all
);

    line_st_e          st_q  [NUM_LINES];
    logic [DATA_W-1:0] dat_q [NUM_LINES];

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        always_ff @(posedge clk) begin
            if (rst) begin
                st_q[g]  <= LN_CLEAN;
                dat_q[g] <= '0;
            end else begin
                if (own_we && own_idx == IDX_W'(g)) begin
                    st_q[g]  <= LN_CLEAN;
                    dat_q[g] <= own_dat;
                end
                if (req_we && req_idx == IDX_W'(g)) begin
                    st_q[g] <= req_nxt;
                end
            end
        end
        assign st_all[g] = st_q[g];
    end

    assign rd_a_st  = st_q[rd_a_idx];
    assign rd_a_dat = dat_q[rd_a_idx];
    assign rd_b_st  = st_q[rd_b_idx];

    AST_RESET_CLEAN: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (st_all == '0)); // R1

endmodule

// File: rtl/coh_req_engine.sv
module coh_req_engine
    import coh_mem_pkg::*;
#(
    parameter int IDX_W  = 4,
    parameter int DATA_W = 32
) (
    input  logic              req_valid,
    input  bus_op_e           req_op,
    input  logic [IDX_W-1:0]  req_idx,
    input  line_st_e          req_st,
    input  logic [DATA_W-1:0] req_dat,
    input  logic              wb_valid,
    input  logic [IDX_W-1:0]  wb_idx,
    input  line_st_e          wb_st,
    input  logic [DATA_W-1:0] wb_dat,
    output logic              own_we,
    output logic              req_we,
    output line_st_e          req_nxt,
    output logic              send,
    output logic [DATA_W-1:0] send_dat,
    output logic              err
);

    logic      wb_ok, wb_bad, req_live, fwd_hit;
    line_st_e  eff_st;
    req_act_t  act;

    always_comb begin
        wb_ok    = wb_valid && (wb_st == LN_WAITWB);
        wb_bad   = wb_valid && !wb_ok;
        req_live = req_valid && (req_op != BUS_IDLE);
        fwd_hit  = wb_ok && req_live && (wb_idx == req_idx);
        eff_st   = fwd_hit ? LN_CLEAN : req_st;
        send_dat = fwd_hit ? wb_dat : req_dat;
        act      = req_decide(eff_st, req_live ? req_op : BUS_IDLE);
        own_we   = wb_ok;
        req_we   = act.wr;
        req_nxt  = act.nxt;
        send     = act.send;
        err      = act.err || wb_bad;
    end

endmodule

// File: rtl/coh_rsp_pipe.sv
module coh_rsp_pipe #(
    parameter int LAT = 2,
    parameter int W   = 39
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_v,
    input  logic [W-1:0] in_p,
    output logic         out_v,
    output logic [W-1:0] out_p
);

    logic [LAT-1:0] v_q;
    logic [W-1:0]   p_q [LAT];

    always_ff @(posedge clk) begin
        if (rst) begin
            v_q <= '0;
        end else begin
            v_q[0] <= in_v;
            for (int i = 1; i < LAT; i++) begin
                v_q[i] <= v_q[i-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        p_q[0] <= in_p;
        for (int i = 1; i < LAT; i++) begin
            p_q[i] <= p_q[i-1];
        end
    end

    assign out_v = v_q[LAT-1];
    assign out_p = p_q[LAT-1];

    AST_PIPE_ENTRY: assert property (@(posedge clk) disable iff (rst)
        in_v |=> v_q[0]); // R9

endmodule

// File: rtl/memside_coh_tracker.sv
module memside_coh_tracker
    import coh_mem_pkg::*;
#(
    parameter int NUM_LINES = 16,
    parameter int DATA_W    = 32,
    parameter int ID_W      = 3,
    parameter int RSP_LAT   = 2,
    localparam int IDX_W    = $clog2(NUM_LINES),
    localparam int PAY_W    = ID_W + IDX_W + DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [IDX_W-1:0]  req_addr,
    input  logic [ID_W-1:0]   req_src,
    input  logic              wb_valid,
    input  logic [IDX_W-1:0]  wb_addr,
    input  logic [DATA_W-1:0] wb_data,
    output logic              rsp_valid,
    output logic [ID_W-1:0]   rsp_dst,
    output logic [IDX_W-1:0]  rsp_addr,
    output logic [DATA_W-1:0] rsp_data,
    output logic              proto_err
);

    line_st_e                  rd_a_st, rd_b_st, req_nxt;
    logic [DATA_W-1:0]         rd_a_dat, send_dat;
    logic                      own_we, req_we, send, err_c;
    logic [NUM_LINES-1:0][1:0] st_all;
    logic [PAY_W-1:0]          pay_out;

    coh_line_array #(.NUM_LINES(NUM_LINES), .DATA_W(DATA_W)) u_array (
        .clk      (clk),
        .rst      (rst),
        .rd_a_idx (req_addr),
        .rd_a_st  (rd_a_st),
        .rd_a_dat (rd_a_dat),
        .rd_b_idx (wb_addr),
        .rd_b_st  (rd_b_st),
        .own_we   (own_we),
        .own_idx  (wb_addr),
        .own_dat  (wb_data),
        .req_we   (req_we),
        .req_idx  (req_addr),
        .req_nxt  (req_nxt),
        .st_all   (st_all)
    );

    coh_req_engine #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_engine (
        .req_valid (req_valid),
        .req_op    (bus_op_e'(req_op)),
        .req_idx   (req_addr),
        .req_st    (rd_a_st),
        .req_dat   (rd_a_dat),
        .wb_valid  (wb_valid),
        .wb_idx    (wb_addr),
        .wb_st     (rd_b_st),
        .wb_dat    (wb_data),
        .own_we    (own_we),
        .req_we    (req_we),
        .req_nxt   (req_nxt),
        .send      (send),
        .send_dat  (send_dat),
        .err       (err_c)
    );

    coh_rsp_pipe #(.LAT(RSP_LAT), .W(PAY_W)) u_pipe (
        .clk   (clk),
        .rst   (rst),
        .in_v  (send),
        .in_p  ({req_src, req_addr, send_dat}),
        .out_v (rsp_valid),
        .out_p (pay_out)
    );

    assign {rsp_dst, rsp_addr, rsp_data} = pay_out;

    always_ff @(posedge clk) begin
        if (rst) proto_err <= 1'b0;
        else     proto_err <= err_c;
    end

    AST_EXCL_OWNS: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_op == BUS_RD_EXCL && st_all[req_addr] == LN_CLEAN)
        |=> (st_all[$past(req_addr)] == LN_OWNED)); // R3

    AST_OWNED_WAITS: assert property (@(posedge clk) disable iff (rst)
        (req_valid && (req_op == BUS_RD_SHARED || req_op == BUS_RELEASE)
         && st_all[req_addr] == LN_OWNED)
        |=> (st_all[$past(req_addr)] == LN_WAITWB) && !proto_err); // R4

    AST_WB_CLEANS: assert property (@(posedge clk) disable iff (rst)
        (wb_valid && st_all[wb_addr] == LN_WAITWB
         && !(req_valid && req_op != BUS_IDLE && req_addr == wb_addr))
        |=> (st_all[$past(wb_addr)] == LN_CLEAN)); // R6

    AST_ERR_KEEPS: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_op != BUS_IDLE && st_all[req_addr] == LN_WAITWB
         && !(wb_valid && wb_addr == req_addr))
        |=> proto_err && (st_all[$past(req_addr)] == LN_WAITWB)); // R7

endmodule

// File: tb/test_memside_coh_tracker.sv
`timescale 1ns/1ps
module test_memside_coh_tracker;

    localparam int LAT = 2;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic [1:0]  req_op;
    logic [3:0]  req_addr;
    logic [2:0]  req_src;
    logic        wb_valid;
    logic [3:0]  wb_addr;
    logic [31:0] wb_data;
    logic        rsp_valid;
    logic [2:0]  rsp_dst;
    logic [3:0]  rsp_addr;
    logic [31:0] rsp_data;
    logic        proto_err;

    int checks   = 0;
    int failures = 0;

    always #2 clk = ~clk;

    memside_coh_tracker #(.RSP_LAT(LAT)) i_memside_coh_tracker (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr), .req_src(req_src),
        .wb_valid(wb_valid), .wb_addr(wb_addr), .wb_data(wb_data),
        .rsp_valid(rsp_valid), .rsp_dst(rsp_dst), .rsp_addr(rsp_addr),
        .rsp_data(rsp_data), .proto_err(proto_err)
    );

    typedef struct packed {
        logic [1:0]  op;
        logic [3:0]  addr;
        logic [2:0]  src;
        logic        wbv;
        logic [3:0]  wba;
        logic [31:0] wbd;
        logic        rv;
        logic [31:0] rd;
        logic        er;
        logic [7:0]  rq;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VECS [NV] = '{
        '{2'b01, 4'd3, 3'd1, 1'b0, 4'd0, 32'h0,        1'b1, 32'h0,        1'b0, 8'd2},  // R2
        '{2'b00, 4'd0, 3'd0, 1'b1, 4'd5, 32'h5555AAAA, 1'b0, 32'h0,        1'b1, 8'd8},  // R8
        '{2'b10, 4'd3, 3'd2, 1'b0, 4'd0, 32'h0,        1'b1, 32'h0,        1'b0, 8'd3},  // R3
        '{2'b01, 4'd3, 3'd4, 1'b0, 4'd0, 32'h0,        1'b0, 32'h0,        1'b0, 8'd4},  // R4
        '{2'b10, 4'd3, 3'd1, 1'b0, 4'd0, 32'h0,        1'b0, 32'h0,        1'b1, 8'd7},  // R7
        '{2'b00, 4'd0, 3'd0, 1'b1, 4'd3, 32'hCAFE0003, 1'b0, 32'h0,        1'b0, 8'd6},  // R6
        '{2'b01, 4'd3, 3'd5, 1'b0, 4'd0, 32'h0,        1'b1, 32'hCAFE0003, 1'b0, 8'd6},  // R6
        '{2'b10, 4'd7, 3'd0, 1'b0, 4'd0, 32'h0,        1'b1, 32'h0,        1'b0, 8'd3},  // R3
        '{2'b10, 4'd7, 3'd6, 1'b0, 4'd0, 32'h0,        1'b0, 32'h0,        1'b0, 8'd5},  // R5
        '{2'b11, 4'd7, 3'd6, 1'b0, 4'd0, 32'h0,        1'b0, 32'h0,        1'b0, 8'd4},  // R4
        '{2'b00, 4'd0, 3'd0, 1'b1, 4'd7, 32'h00000077, 1'b0, 32'h0,        1'b0, 8'd6},  // R6
        '{2'b01, 4'd7, 3'd3, 1'b0, 4'd0, 32'h0,        1'b1, 32'h00000077, 1'b0, 8'd6},  // R6
        '{2'b11, 4'd9, 3'd2, 1'b0, 4'd0, 32'h0,        1'b0, 32'h0,        1'b0, 8'd11}, // R11
        '{2'b10, 4'd9, 3'd2, 1'b0, 4'd0, 32'h0,        1'b1, 32'h0,        1'b0, 8'd11}, // R11
        '{2'b01, 4'd9, 3'd4, 1'b0, 4'd0, 32'h0,        1'b0, 32'h0,        1'b0, 8'd4},  // R4
        '{2'b01, 4'd9, 3'd1, 1'b1, 4'd9, 32'h99990009, 1'b1, 32'h99990009, 1'b0, 8'd10}, // R10
        '{2'b10, 4'd9, 3'd7, 1'b0, 4'd0, 32'h0,        1'b1, 32'h99990009, 1'b0, 8'd10}  // R10
    };

    task automatic chk(input bit ok, input int rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL R%0d %s: actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    task automatic idle_inputs();
        req_valid = 1'b0; req_op = 2'b00; req_addr = '0; req_src = '0;
        wb_valid = 1'b0; wb_addr = '0; wb_data = '0;
    endtask

    task automatic run_vec(input vec_t v);
        @(negedge clk);
        req_valid = (v.op != 2'b00); req_op = v.op; req_addr = v.addr; req_src = v.src;
        wb_valid = v.wbv; wb_addr = v.wba; wb_data = v.wbd;
        for (int n = 1; n <= LAT; n++) begin
            @(negedge clk);
            if (n == 1) begin
                chk(proto_err == v.er, v.rq, "proto_err", 32'(proto_err), 32'(v.er));
                idle_inputs();
            end
            if (n < LAT)
                chk(rsp_valid == 1'b0, 9, "early rsp_valid", 32'(rsp_valid), 32'h0);
        end
        chk(rsp_valid == v.rv, v.rq, "rsp_valid", 32'(rsp_valid), 32'(v.rv));
        if (v.rv) begin
            chk(rsp_data == v.rd, v.rq, "rsp_data", rsp_data, v.rd);
            chk(rsp_dst == v.src, v.rq, "rsp_dst", 32'(rsp_dst), 32'(v.src));
            chk(rsp_addr == v.addr, v.rq, "rsp_addr", 32'(rsp_addr), 32'(v.addr));
        end
        @(negedge clk);
        chk(rsp_valid == 1'b0, 9, "rsp_valid one cycle", 32'(rsp_valid), 32'h0);
        chk(proto_err == 1'b0, 7, "proto_err one cycle", 32'(proto_err), 32'h0);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        idle_inputs();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: outputs quiet after reset
        chk(rsp_valid == 1'b0, 1, "rsp_valid after reset", 32'(rsp_valid), 32'h0);
        chk(proto_err == 1'b0, 1, "proto_err after reset", 32'(proto_err), 32'h0);

        // R1: every line reads back zero and clean
        for (int a = 0; a < 16; a++) begin
            vec_t v;
            v = '{2'b01, 4'(a), 3'(a), 1'b0, 4'd0, 32'h0, 1'b1, 32'h0, 1'b0, 8'd1};
            run_vec(v);
        end

        for (int i = 0; i < NV; i++) run_vec(VECS[i]);

        // R9: back-to-back requests give back-to-back responses
        @(negedge clk);
        req_valid = 1'b1; req_op = 2'b01; req_addr = 4'd3; req_src = 3'd1;
        for (int n = 1; n <= LAT + 1; n++) begin
            @(negedge clk);
            if (n == LAT) begin
                chk(rsp_valid && rsp_dst == 3'd1, 9, "first pipelined rsp",
                    32'({rsp_valid, rsp_dst}), 32'({1'b1, 3'd1}));
            end
            if (n == LAT + 1) begin
                chk(rsp_valid && rsp_dst == 3'd2 && rsp_addr == 4'd7, 9, "second pipelined rsp",
                    32'({rsp_valid, rsp_dst, rsp_addr}), 32'({1'b1, 3'd2, 4'd7}));
            end
            if (n == 1) begin
                req_addr = 4'd7; req_src = 3'd2;
            end
            if (n == 2) idle_inputs();
        end
        @(negedge clk);

        // R1: reset mid-run returns an owned line to clean zero
        run_vec('{2'b10, 4'd4, 3'd3, 1'b0, 4'd0, 32'h0, 1'b1, 32'h0, 1'b0, 8'd3});
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        run_vec('{2'b01, 4'd3, 3'd2, 1'b0, 4'd0, 32'h0, 1'b1, 32'h0, 1'b0, 8'd1});
        run_vec('{2'b01, 4'd4, 3'd2, 1'b0, 4'd0, 32'h0, 1'b1, 32'h0, 1'b0, 8'd1});

        // R8: stray owner data is discarded, memory keeps zero
        run_vec('{2'b00, 4'd0, 3'd0, 1'b1, 4'd4, 32'hDEADBEEF, 1'b0, 32'h0, 1'b1, 8'd8});
        run_vec('{2'b01, 4'd4, 3'd6, 1'b0, 4'd0, 32'h0, 1'b1, 32'h0, 1'b0, 8'd8});

        finish_run();
    end

endmodule